// File: doc/BRIEF.md
# Bit-Slice Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a processor datapath. One bit-slice cell is repeated across the word. Each cell forms AND, OR and a full-adder sum from conditionally inverted operand bits, and a per-bit multiplexer picks one of them. The carry ripples from the least significant slice to the most significant one.

A 4-bit operation code drives the unit. Bit 3 inverts operand `a`. Bit 2 inverts operand `b` and also supplies the carry into bit 0. Bits 1:0 choose the slice output.

The unit also produces three other results:
- A signed-compare result, formed from the difference and placed in bit 0.
- A zero flag on the result, which a branch-on-equal uses after a subtraction.
- A signed overflow flag.

Top module: `bitslice_alu`

## Requirements
- R1: Code 4'b0000 returns `a & b` on every bit.
- R2: Code 4'b0001 returns `a | b` on every bit.
- R3: Code 4'b0010 returns `a + b` modulo 2^32.
- R4: Code 4'b0110 returns `a - b` modulo 2^32, formed as `a + ~b + 1`.
- R5: Code 4'b0111 returns 1 in bit 0 when `a` is less than `b` as signed two's complement numbers, and 0 otherwise. Bits 31:1 are zero. The comparison stays correct when the subtraction overflows.
- R6: Code 4'b1100 returns `~(a | b)` on every bit.
- R7: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R8: For codes 4'b0010 and 4'b0110, `overflow` is 1 exactly when the signed sum or difference does not fit in 32 bits. For every other code, `overflow` is 0.
- R9: Every code not listed in R1 to R6 returns a `result` of 0, so `zero` reads 1 and `overflow` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| opCode | input | 4 | Operation: {invert a, invert b, select[1:0]} |
| result | output | 32 | Selected result word |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The assertions assume that `a`, `b` and `opCode` are settled, known values whenever they are evaluated. The assertions are combinational, so they treat any 4-bit code as legal and compare the outputs against an arithmetic model.

The stimulus changes inputs only on one clock edge and samples on the opposite edge, so every check sees a settled word. The stimulus draws the opcode both from the six defined codes and from the full 4-bit space. It also uses directed operands around the most negative and most positive values, so that the overflow and signed-compare paths are covered.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  localparam logic [OP_W-1:0] OP_AND = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OP_NOR = 4'b1100;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sliceSel_e;

  typedef struct packed {
    logic      opValid;
    logic      invA;
    logic      invB;
    logic      carryIn;
    logic      arith;
    sliceSel_e sel;
  } aluCtrl_t;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic      aBit,
  input  logic      bBit,
  input  logic      carryIn,
  input  sliceSel_e sel,
  output logic      resBit,
  output logic      sumBit
);
  always_comb begin
    sumBit = aBit ^ bBit ^ carryIn;
    unique case (sel)
      SEL_AND: resBit = aBit & bBit;
      SEL_OR:  resBit = aBit | bBit;
      SEL_SUM: resBit = sumBit;
      default: resBit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);
  always_comb begin
    ctrl = '{opValid: 1'b0, invA: 1'b0, invB: 1'b0, carryIn: 1'b0,
             arith: 1'b0, sel: SEL_AND};
    unique case (opCode)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: begin
        ctrl.opValid = 1'b1;
        ctrl.invA    = opCode[3];
        ctrl.invB    = opCode[2];
        ctrl.carryIn = opCode[2];
        ctrl.sel     = sliceSel_e'(opCode[1:0]);
        ctrl.arith   = (opCode[1:0] == 2'b10);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] aEff, bEff, sliceRes, sumVec;
  logic [WIDTH:0]   carryVec;
  logic             ovfRaw, lessBit;
  logic [WIDTH-1:0] wordOut;

  always_comb begin
    aEff = a ^ {WIDTH{ctrl.invA}};
    bEff = b ^ {WIDTH{ctrl.invB}};
    carryVec = '0;
    carryVec[0] = ctrl.carryIn;
    for (int i = 0; i < WIDTH; i++) begin
      carryVec[i+1] = (aEff[i] & bEff[i]) | (aEff[i] & carryVec[i]) |
                      (bEff[i] & carryVec[i]);
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : gSlice
    alu_bit_slice uSlice (
      .aBit   (aEff[g]),
      .bBit   (bEff[g]),
      .carryIn(carryVec[g]),
      .sel    (ctrl.sel),
      .resBit (sliceRes[g]),
      .sumBit (sumVec[g])
    );
  end

  always_comb begin
    ovfRaw  = carryVec[WIDTH] ^ carryVec[MSB];
    lessBit = sumVec[MSB] ^ ovfRaw;
    wordOut = sliceRes;
    if (ctrl.sel == SEL_LESS) wordOut[0] = lessBit;
    result   = ctrl.opValid ? wordOut : '0;
    overflow = ctrl.opValid & ctrl.arith & ovfRaw;
    zero     = ~|result;
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
(
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [3:0]  opCode,
  output logic [31:0] result,
  output logic        zero,
  output logic        overflow
);
  aluCtrl_t ctrl;

  alu_control uCtrl (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(DATA_W)) uDp (
    .a       (a),
    .b       (b),
    .ctrl    (ctrl),
    .result  (result),
    .zero    (zero),
    .overflow(overflow)
  );
endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker (
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [3:0]  opCode,
  input logic [31:0] result,
  input logic        zero,
  input logic        overflow
);
  logic [31:0] addRef, subRef;
  always_comb begin
    addRef = a + b;
    subRef = a - b;
    if (opCode == 4'b0000) AST_AND_WORD: assert (result == (a & b)); // R1
    if (opCode == 4'b0001) AST_OR_WORD: assert (result == (a | b)); // R2
    if (opCode == 4'b0010) AST_ADD_WORD: assert (result == addRef); // R3
    if (opCode == 4'b0110) AST_SUB_WORD: assert (result == subRef); // R4
    if (opCode == 4'b0111) AST_SLT_VALUE: assert (result == {31'b0, ($signed(a) < $signed(b))}); // R5
    if (opCode == 4'b1100) AST_NOR_WORD: assert (result == ~(a | b)); // R6
    AST_ZERO_FLAG: assert (zero == (result == 32'd0)); // R7
    if (opCode != 4'b0010 && opCode != 4'b0110) AST_NO_OVERFLOW: assert (!overflow); // R8
    if (opCode == 4'b0010) AST_ADD_OVF: assert (overflow == ((a[31] == b[31]) && (addRef[31] != a[31]))); // R8
    if (!(opCode inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}))
      AST_UNUSED_ZERO: assert (result == 32'd0 && zero); // R9
  end
endmodule

bind bitslice_alu bitslice_alu_checker uChk (
  .a(a), .b(b), .opCode(opCode),
  .result(result), .zero(zero), .overflow(overflow)
);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  opCode = '0;
  logic [31:0] result;
  logic        zero, overflow;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bitslice_alu u_bitslice_alu (
    .a(a), .b(b), .opCode(opCode),
    .result(result), .zero(zero), .overflow(overflow)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] refResult(input logic [3:0] op, input logic [31:0] x, y);
    case (op)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return {31'b0, ($signed(x) < $signed(y))};
      4'b1100: return ~(x | y);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic refOvf(input logic [3:0] op, input logic [31:0] x, y);
    logic [31:0] s;
    if (op == 4'b0010) begin
      s = x + y;
      return (x[31] == y[31]) && (s[31] != x[31]);
    end
    if (op == 4'b0110) begin
      s = x - y;
      return (x[31] != y[31]) && (s[31] != x[31]);
    end
    return 1'b0;
  endfunction

  task automatic runOne(input logic [3:0] op, input logic [31:0] x, y);
    logic [31:0] expRes;
    logic expOvf;
    @(posedge clk);
    opCode = op; a = x; b = y;
    @(negedge clk);
    expRes = refResult(op, x, y);
    expOvf = refOvf(op, x, y);
    compared++;
    if (result !== expRes) begin
      mismatched++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", reqOf(op), op, x, y, result, expRes);
    end
    compared++;
    if (zero !== (expRes == 32'd0)) begin  // R7
      mismatched++;
      $display("FAIL R7 zero op=%b actual=%b expected=%b", op, zero, (expRes == 32'd0));
    end
    compared++;
    if (overflow !== expOvf) begin  // R8
      mismatched++;
      $display("FAIL R8 overflow op=%b a=%h b=%h actual=%b expected=%b", op, x, y, overflow, expOvf);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [6];
    ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    void'($urandom(32'h5EED_0369));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give AND of zeros, R1/R7
    runOne(4'b0000, 32'd0, 32'd0);
    // directed corners
    runOne(4'b0000, 32'hF0F0_AAAA, 32'hFF00_5555);        // R1
    runOne(4'b0001, 32'hF0F0_0000, 32'h0F0F_0001);        // R2
    runOne(4'b0010, 32'hFFFF_FFFF, 32'd1);                // R3 wrap, zero R7
    runOne(4'b0010, 32'h7FFF_FFFF, 32'd1);                // R3 R8 overflow
    runOne(4'b0010, 32'h8000_0000, 32'h8000_0000);        // R8 negative overflow
    runOne(4'b0110, 32'd5, 32'd5);                        // R4 equal, R7
    runOne(4'b0110, 32'h8000_0000, 32'd1);                // R4 R8 overflow
    runOne(4'b0111, 32'h8000_0000, 32'd1);                // R5 overflowed compare -> 1
    runOne(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);        // R5 overflowed compare -> 0
    runOne(4'b0111, 32'hFFFF_FFFB, 32'd3);                // R5 negative < positive
    runOne(4'b0111, 32'd3, 32'd3);                        // R5 equal -> 0
    runOne(4'b1100, 32'h0000_FFFF, 32'h00FF_0000);        // R6
    runOne(4'b1100, 32'hFFFF_FFFF, 32'd0);                // R6 zero result
    for (int c = 0; c < 16; c++)                          // R9 sweep all codes
      runOne(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op;
      logic [31:0] x, y;
      op = ($urandom % 4 == 0) ? 4'($urandom) : ops[$urandom % 6];
      x = $urandom;
      y = ($urandom % 8 == 0) ? x : $urandom;
      if ($urandom % 8 == 0) x[31:30] = 2'b10;
      runOne(op, x, y);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule